// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block decides when the memory side of a microcontroller system may sleep. It samples the processor's address-latch strobe in the domain of a separate input clock. While automatic power-down is enabled and the strobe shows no transition, a four-bit idle counter advances once per input clock period. When the counter saturates, the block raises a power-down indicator and a matching buffer-disable signal. While buffer-disable is high, the address and data bus buffers are off, so bus noise cannot wake the memories.

Software programs the block through a small register file with a write port and a combinational read port. One control bit forces power-down at once and bypasses the counter. Four blocking bits each hold one input (the read strobe, the program-store strobe, the address-latch strobe and one general pin) at 0 before it reaches downstream logic, which saves switching power. A power-on reset clears the registers. A separate functional reset clears only the idle counter and the synchronizer, and the mode settings survive it.

Top module: `apd_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), every register reads 0x00, and `pdn_o` and `buf_dis_o` are 0.
- R2: Register map. Address 0 holds the enable bit at bit 1. Address 1 holds the blocking bits at bits 3:0: bit 0 is read, bit 1 is program-store, bit 2 is address-latch, bit 3 is the pin. Address 2 holds the force bit at bit 0. All other bits, and all of address 3, read 0 whatever is written.
- R3: Let the enable bit be written to 1 at clock edge W with the strobe idle. `pdn_o` is then 0 after edge W+14 and 1 after edge W+15.
- R4: The idle counter saturates. `pdn_o` stays 1 for as long as the strobe stays idle.
- R5: A strobe transition clears the counter on the third rising clock edge after the input changes (two synchronizer flops, then an edge-detect flop). From that edge on, `pdn_o` is 0 unless force is set, and it returns to 1 fifteen edges later.
- R6: With the force bit at 1, `pdn_o` is 1 from the edge that writes it. This holds whatever the enable bit, the counter and the strobe activity are. Clearing the force bit with enable at 0 brings `pdn_o` to 0.
- R7: `buf_dis_o` is 1 exactly when `pdn_o` is 1.
- R8: Each gated output equals its input when its blocking bit is 0 and is 0 when its blocking bit is 1. The path is combinational.
- R9: `rst_n` low clears the idle counter but leaves all register contents unchanged. Registers change only on writes.
- R10: With enable 0 and force 0, `pdn_o` stays 0 however long the strobe is idle.
- R11: When the clearing edge of a strobe transition falls on the same edge that would take the counter from 14 to 15, the clear wins and `pdn_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that sets the idle time base |
| por_n | input | 1 | Power-on reset, active low, asynchronous, clears registers |
| rst_n | input | 1 | Functional reset, active low, asynchronous, clears counter and synchronizer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ale_i | input | 1 | Address-latch strobe, asynchronous |
| rd_i | input | 1 | Read strobe to be gated |
| psen_i | input | 1 | Program-store strobe to be gated |
| pin_i | input | 1 | General pin to be gated |
| ale_o | output | 1 | Gated address-latch strobe |
| rd_o | output | 1 | Gated read strobe |
| psen_o | output | 1 | Gated program-store strobe |
| pin_o | output | 1 | Gated general pin |
| pdn_o | output | 1 | Power-down indicator |
| buf_dis_o | output | 1 | Bus buffer disable |

## Verification
A strobe transition can reach the edge detector on the same clock edge at which the idle counter would saturate. The bench provokes this by enabling the counter and toggling the strobe after edge W+12, so the clear lands on edge W+15. At that edge the clear must win: `pdn_o` is 0 after W+15 and rises only fifteen edges after the clear. A second overlap puts force and strobe activity together, and `pdn_o` must stay high through the transition.

// File: rtl/apd_ctrl.sv
module apd_ctrl #(
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int IDLE_W = 4,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          ale_i,
  input  logic          rd_i,
  input  logic          psen_i,
  input  logic          pin_i,
  output logic          ale_o,
  output logic          rd_o,
  output logic          psen_o,
  output logic          pin_o,
  output logic          pdn_o,
  output logic          buf_dis_o
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};
  localparam logic [AW-1:0] A_MODE  = AW'(0);
  localparam logic [AW-1:0] A_BLOCK = AW'(1);
  localparam logic [AW-1:0] A_CTRL  = AW'(2);

  logic              en_q;
  logic [3:0]        blk_q;
  logic              frc_q;
  logic [SYNC_N:0]   sh_q;
  logic [IDLE_W-1:0] cnt_q;
  logic              act_det;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      blk_q <= '0;
      frc_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  en_q  <= wr_data[1];
        A_BLOCK: blk_q <= wr_data[3:0];
        A_CTRL:  frc_q <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MODE:  rd_data[1]   = en_q;
      A_BLOCK: rd_data[3:0] = blk_q;
      A_CTRL:  rd_data[0]   = frc_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_N-1:0], ale_i};
  end

  assign act_det = sh_q[SYNC_N] ^ sh_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_q || act_det) cnt_q <= '0;
    else if (cnt_q != IDLE_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign pdn_o     = frc_q | (en_q & (cnt_q == IDLE_MAX));
  assign buf_dis_o = pdn_o;

  assign rd_o   = rd_i   & ~blk_q[0];
  assign psen_o = psen_i & ~blk_q[1];
  assign ale_o  = ale_i  & ~blk_q[2];
  assign pin_o  = pin_i  & ~blk_q[3];
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int AW     = 2,
  parameter int IDLE_W = 4
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic              wr_bit0,
  input logic              pdn_o,
  input logic              act_det,
  input logic [IDLE_W-1:0] cnt_q,
  input logic              frc_q,
  input logic [5:0]        regs
);
  localparam logic [IDLE_W-1:0] NEAR_MAX = {{(IDLE_W-1){1'b1}}, 1'b0};

  p_rise_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pdn_o) |-> (frc_q || $past(cnt_q) == NEAR_MAX));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!por_n)
    (pdn_o && rst_n && !act_det && !wr_en) |=> (pdn_o || !rst_n));

  p_edge_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
    (rst_n && act_det && !frc_q && !(wr_en && wr_addr == AW'(2))) |=> !pdn_o);

  p_force_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_addr == AW'(2) && wr_bit0) |=> pdn_o);

  p_regs_keep_r9: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(regs));
endmodule

bind apd_ctrl apd_ctrl_chk #(.AW(AW), .IDLE_W(IDLE_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bit0(wr_data[0]), .pdn_o(pdn_o),
  .act_det(act_det), .cnt_q(cnt_q), .frc_q(frc_q),
  .regs({en_q, blk_q, frc_q})
);

// File: tb/sim_apd_ctrl.sv
module sim_apd_ctrl;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic ale_i = 1'b0, rd_i = 1'b0, psen_i = 1'b0, pin_i = 1'b0;
  logic ale_o, rd_o, psen_o, pin_o, pdn_o, buf_dis_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  apd_ctrl u0 (.*);

  // {block[3:0], inputs {pin,ale,psen,rd}, expected {pin,ale,psen,rd}}
  localparam logic [11:0] VEC [8] = '{
    12'b0000_1111_1111, 12'b0000_0101_0101, 12'b0001_1111_1110,
    12'b0010_1111_1101, 12'b0100_1111_1011, 12'b1000_1111_0111,
    12'b1111_1111_0000, 12'b1010_0110_0100};

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(string tag, logic [1:0] a, logic [7:0] exp);
    rd_addr = a; #1; chk(tag, rd_data, exp);
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitn(3);
    por_n = 1'b1; rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    for (int a = 0; a < 4; a++) rdchk("R1 reg", 2'(a), 8'h00);
    chk("R1 pdn", {7'b0, pdn_o}, 8'h00);
    chk("R1 bufdis", {7'b0, buf_dis_o}, 8'h00);
    // R2 map and unused bits
    wr(2'd0, 8'hFF); rdchk("R2 mode", 2'd0, 8'h02);
    wr(2'd1, 8'hFF); rdchk("R2 block", 2'd1, 8'h0F);
    wr(2'd3, 8'hFF); rdchk("R2 addr3", 2'd3, 8'h00);
    wr(2'd2, 8'hFF); rdchk("R2 ctrl", 2'd2, 8'h01);
    chk("R6 force immediate", {7'b0, pdn_o}, 8'h01);
    wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    // R8 vector table
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, {4'b0, VEC[i][11:8]});
      {pin_i, ale_i, psen_i, rd_i} = VEC[i][7:4];
      #1;
      chk("R8 gating", {4'b0, pin_o, ale_o, psen_o, rd_o}, {4'b0, VEC[i][3:0]});
    end
    {pin_i, ale_i, psen_i, rd_i} = 4'b0;
    wr(2'd1, 8'h00);
    waitn(4);
    // R3 idle timing
    wr(2'd0, 8'h02);
    waitn(14); chk("R3 before W+15", {7'b0, pdn_o}, 8'h00);
    waitn(1);  chk("R3 at W+15", {7'b0, pdn_o}, 8'h01);
    chk("R7 bufdis follows", {7'b0, buf_dis_o}, 8'h01);
    // R4 saturation
    waitn(40); chk("R4 no wrap", {7'b0, pdn_o}, 8'h01);
    // R5 activity clears
    ale_i = 1'b1;
    waitn(2); chk("R5 not yet cleared", {7'b0, pdn_o}, 8'h01);
    waitn(1); chk("R5 cleared", {7'b0, pdn_o}, 8'h00);
    chk("R7 bufdis low", {7'b0, buf_dis_o}, 8'h00);
    waitn(14); chk("R5 still low", {7'b0, pdn_o}, 8'h00);
    waitn(1);  chk("R5 rises again", {7'b0, pdn_o}, 8'h01);
    // R11 clear on the saturating edge
    wr(2'd0, 8'h00); waitn(3);
    wr(2'd0, 8'h02);
    waitn(12); ale_i = 1'b0;
    waitn(3); chk("R11 clear wins", {7'b0, pdn_o}, 8'h00);
    waitn(14); chk("R11 still low", {7'b0, pdn_o}, 8'h00);
    waitn(1);  chk("R11 rises later", {7'b0, pdn_o}, 8'h01);
    // R6 force with activity, enable off
    wr(2'd0, 8'h00);
    chk("R10 disable drops pdn", {7'b0, pdn_o}, 8'h00);
    wr(2'd2, 8'h01); chk("R6 force on", {7'b0, pdn_o}, 8'h01);
    ale_i = 1'b1; waitn(4); chk("R6 activity ignored", {7'b0, pdn_o}, 8'h01);
    wr(2'd2, 8'h00); chk("R6 force off", {7'b0, pdn_o}, 8'h00);
    // R10 disabled stays low
    waitn(30); chk("R10 no power-down", {7'b0, pdn_o}, 8'h00);
    // R9 functional reset
    wr(2'd1, 8'h05); wr(2'd0, 8'h02);
    waitn(20); chk("R9 pre", {7'b0, pdn_o}, 8'h01);
    rst_n = 1'b0;
    waitn(1); chk("R9 counter cleared", {7'b0, pdn_o}, 8'h00);
    rdchk("R9 mode kept", 2'd0, 8'h02);
    rdchk("R9 block kept", 2'd1, 8'h05);
    rst_n = 1'b1;
    waitn(30); chk("R9 counts after reset", {7'b0, pdn_o}, 8'h01);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule